// File: doc/BRIEF.md
# Quad-Issue Dispatch Group Former

This block sits between instruction decode and the execution units of a four-wide in-order core. Each cycle it looks at a window of up to four decoded instructions, oldest in position 0, each carrying a class code, a valid bit and a precision bit. It decides how many of those instructions, counted from the oldest, can leave together as one dispatch group. For each issued instruction it names the execution resource it occupies: integer unit 0, integer unit 1, the load/store unit, the control-transfer unit, the FP adder or the FP multiplier. Instructions that must run alone are marked as taking the whole group.

The decision follows the core's pairing rules. Slots fill strictly in order, so the group is always a leading run of the window. Integer, shift, compare and memory work is confined to the lower slots. The two integer units are asymmetric and must be claimed in age order. Several classes can only start a group or must issue alone. FP work of both precisions may not share a group. The group count and per-slot unit codes are registered, and they appear one clock after the window is presented.

Top module: `dgf_group_former`

Class codes on `class_i` (instruction k at bits 4k+3..4k): 0 ALU, 1 shift, 2 compare, 3 load, 4 store, 5 conditional integer branch, 6 call/jump/unconditional branch, 7 issue-alone (multi-op, window save/flush, instruction flush, trap, extended ALU, conditional move, multiply, divide), 8 FP adder op, 9 FP multiplier op, 10 FP divide/square root, 11 to 15 reserved. Unit codes on `unit_o` (slot k at bits 3k+2..3k): 0 integer unit 0, 1 integer unit 1, 2 load/store, 3 control transfer, 4 FP adder, 5 FP multiplier, 6 whole group, 7 not issued.

## Requirements
- R1: After reset the group count is 0 and every slot's unit code is 7 (not issued).
- R2: When the stall input is high, or instruction 0 is not valid, the group count is 0; otherwise instruction 0 always issues.
- R3: The count equals the length of the leading run of issuable instructions; the first instruction that cannot join (including a non-valid one) and every later one get unit code 7.
- R4: Classes 0 to 4 may occupy only slots 0, 1 and 2; classes 5, 8 and 9 may occupy any slot.
- R5: A shift (class 1) takes unit 0 and needs both integer units free; a compare (class 2) takes unit 1; an ALU op takes unit 0 if free, else unit 1; unit 0 may never be claimed after unit 1 in the same group, so compare followed by ALU splits while ALU followed by compare pairs.
- R6: Class 7 and the reserved codes 11 to 15 issue only in slot 0, alone, with unit code 6.
- R7: A call/jump (class 6) issues only in slot 0 with unit code 3 and also claims integer unit 1, so no integer instruction may follow it in the group.
- R8: An FP divide/square root (class 10) issues only in slot 0 with unit code 5.
- R9: The first FP instruction (classes 8, 9, 10) of a group fixes its precision from `dbl_i`; a later FP instruction of the other precision ends the group.
- R10: At most one instruction per group uses each of the load/store, FP adder, FP multiplier and control-transfer units, and each integer unit is used at most once.
- R11: A conditional branch may issue in the same group right after the compare that sets its condition codes.
- R12: Outputs are registered: a window presented before a rising edge is reflected after that edge, and the outputs do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_i | input | 1 | Holds the whole window back |
| valid_i | input | 4 | Per-instruction valid, bit 0 oldest |
| class_i | input | 16 | Four 4-bit class codes |
| dbl_i | input | 4 | Per-instruction FP precision, 1 = double |
| count_o | output | 3 | Number of instructions issued (0 to 4) |
| unit_o | output | 12 | Four 3-bit unit codes, one per slot |

## Verification
The bench builds the block with its default four slots and three integer-capable slots, so slot 3 is the only slot where integer and memory classes are refused and all four slots can fill with a mix of integer, memory, branch and FP work. With these values every pairing rule is reachable inside one window: an ALU-compare pair, a shift plus ALU, a branch in slot 3, and FP precision conflicts at any position. Random windows draw all sixteen class codes, both precisions and sparse valid bits, so reserved codes, holes in the window and stall all occur alongside the directed corner cases.

// File: rtl/dgf_pkg.sv
// Shared types for the dispatch group former.
// Assumes four-bit class codes and three-bit unit codes as listed in the brief.
package dgf_pkg;

    localparam int CLS_W  = 4;
    localparam int UNIT_W = 3;

    // Raw class codes carried on the class input.
    localparam logic [CLS_W-1:0] C_ALU    = 4'd0;
    localparam logic [CLS_W-1:0] C_SHIFT  = 4'd1;
    localparam logic [CLS_W-1:0] C_CMP    = 4'd2;
    localparam logic [CLS_W-1:0] C_LOAD   = 4'd3;
    localparam logic [CLS_W-1:0] C_STORE  = 4'd4;
    localparam logic [CLS_W-1:0] C_BRANCH = 4'd5;
    localparam logic [CLS_W-1:0] C_CALL   = 4'd6;
    localparam logic [CLS_W-1:0] C_SOLO   = 4'd7;
    localparam logic [CLS_W-1:0] C_FADD   = 4'd8;
    localparam logic [CLS_W-1:0] C_FMUL   = 4'd9;
    localparam logic [CLS_W-1:0] C_FDIV   = 4'd10;

    // Execution resource named on each slot.
    typedef enum logic [UNIT_W-1:0] {
        U_IEU0  = 3'd0,
        U_IEU1  = 3'd1,
        U_LSU   = 3'd2,
        U_CTI   = 3'd3,
        U_FPA   = 3'd4,
        U_FPM   = 3'd5,
        U_WHOLE = 3'd6,
        U_NONE  = 3'd7
    } dgf_unit_e;

    // Normalised instruction kind after decode.
    typedef enum logic [3:0] {
        K_ALU,
        K_SHIFT,
        K_CMP,
        K_MEM,
        K_BRANCH,
        K_CALL,
        K_SOLO,
        K_FADD,
        K_FMUL,
        K_FDIV
    } dgf_kind_e;

    // Resources already claimed by older instructions of the group.
    typedef struct packed {
        logic open;    // group still accepting instructions
        logic ieu0;
        logic ieu1;
        logic lsu;
        logic cti;
        logic fpa;
        logic fpm;
        logic fp_set;  // an FP instruction has fixed the precision
        logic fp_dbl;  // fixed precision, 1 = double
    } dgf_state_t;

endpackage

// File: rtl/dgf_class_decode.sv
// Class decoder: maps a raw class code to a normalised kind plus placement flags.
// Assumes reserved codes behave like issue-alone instructions.
module dgf_class_decode
    import dgf_pkg::*;
(
    input  logic [CLS_W-1:0] cls_i,
    output dgf_kind_e        kind_o,
    output logic             int_only_o,
    output logic             slot0_only_o,
    output logic             is_fp_o
);

    // Translate the class code into kind and placement restrictions.
    always_comb begin
        kind_o       = K_SOLO;
        int_only_o   = 1'b0;
        slot0_only_o = 1'b0;
        is_fp_o      = 1'b0;
        case (cls_i)
            C_ALU: begin
                kind_o     = K_ALU;
                int_only_o = 1'b1;
            end
            C_SHIFT: begin
                kind_o     = K_SHIFT;
                int_only_o = 1'b1;
            end
            C_CMP: begin
                kind_o     = K_CMP;
                int_only_o = 1'b1;
            end
            C_LOAD, C_STORE: begin
                kind_o     = K_MEM;
                int_only_o = 1'b1;
            end
            C_BRANCH: begin
                kind_o = K_BRANCH;
            end
            C_CALL: begin
                kind_o       = K_CALL;
                slot0_only_o = 1'b1;
            end
            C_FADD: begin
                kind_o  = K_FADD;
                is_fp_o = 1'b1;
            end
            C_FMUL: begin
                kind_o  = K_FMUL;
                is_fp_o = 1'b1;
            end
            C_FDIV: begin
                kind_o       = K_FDIV;
                is_fp_o      = 1'b1;
                slot0_only_o = 1'b1;
            end
            default: begin
                kind_o       = K_SOLO;
                slot0_only_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dgf_slot_stage.sv
// One slot of the group-forming chain.
// Receives the resources claimed by older slots, decides whether its
// instruction joins the group and passes the updated claim set on.
// Assumes the incoming state has open cleared once any older slot refused.
module dgf_slot_stage
    import dgf_pkg::*;
#(
    parameter int SLOT      = 0,
    parameter int INT_SLOTS = 3
) (
    input  dgf_state_t       st_i,
    input  logic             valid_i,
    input  logic [CLS_W-1:0] cls_i,
    input  logic             dbl_i,
    output logic             take_o,
    output dgf_unit_e        unit_o,
    output dgf_state_t       st_o
);

    localparam logic INT_SLOT_OK = (SLOT < INT_SLOTS);
    localparam logic FIRST_SLOT  = (SLOT == 0);

    dgf_kind_e kind;
    logic      int_only;
    logic      slot0_only;
    logic      is_fp;
    logic      fit;
    logic      ends;
    logic      place_ok;
    logic      prec_ok;
    dgf_unit_e unit_want;

    dgf_class_decode u_dec (
        .cls_i        (cls_i),
        .kind_o       (kind),
        .int_only_o   (int_only),
        .slot0_only_o (slot0_only),
        .is_fp_o      (is_fp)
    );

    // Check resource availability for this kind and pick its unit.
    always_comb begin
        fit       = 1'b0;
        ends      = 1'b0;
        unit_want = U_NONE;
        case (kind)
            K_ALU: begin
                fit       = !st_i.ieu1;
                unit_want = st_i.ieu0 ? U_IEU1 : U_IEU0;
            end
            K_SHIFT: begin
                fit       = !st_i.ieu0 && !st_i.ieu1;
                unit_want = U_IEU0;
            end
            K_CMP: begin
                fit       = !st_i.ieu1;
                unit_want = U_IEU1;
            end
            K_MEM: begin
                fit       = !st_i.lsu;
                unit_want = U_LSU;
            end
            K_BRANCH: begin
                fit       = !st_i.cti;
                unit_want = U_CTI;
            end
            K_CALL: begin
                fit       = !st_i.cti && !st_i.ieu1;
                unit_want = U_CTI;
            end
            K_FADD: begin
                fit       = !st_i.fpa;
                unit_want = U_FPA;
            end
            K_FMUL, K_FDIV: begin
                fit       = !st_i.fpm;
                unit_want = U_FPM;
            end
            default: begin
                fit       = 1'b1;
                ends      = 1'b1;
                unit_want = U_WHOLE;
            end
        endcase
    end

    // Slot placement and precision compatibility.
    always_comb begin
        place_ok = (!int_only || INT_SLOT_OK) && (!slot0_only || FIRST_SLOT);
        prec_ok  = !is_fp || !st_i.fp_set || (st_i.fp_dbl == dbl_i);
        take_o   = st_i.open && valid_i && fit && place_ok && prec_ok;
        unit_o   = take_o ? unit_want : U_NONE;
    end

    // Publish the claim set seen by the next younger slot.
    always_comb begin
        st_o      = st_i;
        st_o.open = take_o && !ends;
        if (take_o) begin
            case (unit_want)
                U_IEU0: st_o.ieu0 = 1'b1;
                U_IEU1: st_o.ieu1 = 1'b1;
                U_LSU:  st_o.lsu  = 1'b1;
                U_CTI: begin
                    st_o.cti = 1'b1;
                    if (kind == K_CALL) st_o.ieu1 = 1'b1;
                end
                U_FPA:  st_o.fpa  = 1'b1;
                U_FPM:  st_o.fpm  = 1'b1;
                default: st_o.open = 1'b0;
            endcase
            if (is_fp) begin
                st_o.fp_set = 1'b1;
                st_o.fp_dbl = dbl_i;
            end
        end
    end

endmodule

// File: rtl/dgf_group_former.sv
// Dispatch group former: chains one stage per slot, counts the leading run
// of issued instructions and registers count and per-slot unit codes.
// Assumes instruction 0 is the oldest in the window; reset is synchronous.
module dgf_group_former
    import dgf_pkg::*;
#(
    parameter int SLOTS     = 4,
    parameter int INT_SLOTS = 3,
    localparam int CNT_W    = $clog2(SLOTS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stall_i,
    input  logic [SLOTS-1:0]         valid_i,
    input  logic [SLOTS*CLS_W-1:0]   class_i,
    input  logic [SLOTS-1:0]         dbl_i,
    output logic [CNT_W-1:0]         count_o,
    output logic [SLOTS*UNIT_W-1:0]  unit_o
);

    dgf_state_t             chain [SLOTS+1];
    logic [SLOTS-1:0]       take;
    dgf_unit_e              unit_d [SLOTS];
    logic [CNT_W-1:0]       cnt_d;
    logic [UNIT_W-1:0]      unit_q [SLOTS];
    logic [CNT_W-1:0]       count_q;
    logic                   armed;

    // Seed the chain: nothing claimed, open unless the window is stalled.
    always_comb begin
        chain[0]      = '0;
        chain[0].open = !stall_i;
    end

    generate
        for (genvar k = 0; k < SLOTS; k++) begin : g_slot
            dgf_slot_stage #(
                .SLOT      (k),
                .INT_SLOTS (INT_SLOTS)
            ) u_stage (
                .st_i    (chain[k]),
                .valid_i (valid_i[k]),
                .cls_i   (class_i[k*CLS_W +: CLS_W]),
                .dbl_i   (dbl_i[k]),
                .take_o  (take[k]),
                .unit_o  (unit_d[k]),
                .st_o    (chain[k+1])
            );
        end
    endgenerate

    // Count the instructions that joined the group.
    always_comb begin
        cnt_d = '0;
        for (int k = 0; k < SLOTS; k++) begin
            cnt_d = cnt_d + CNT_W'(take[k]);
        end
    end

    // Register the group decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            for (int k = 0; k < SLOTS; k++) unit_q[k] <= U_NONE;
        end else begin
            count_q <= cnt_d;
            for (int k = 0; k < SLOTS; k++) unit_q[k] <= unit_d[k];
        end
    end

    // Drive the flat output ports.
    always_comb begin
        count_o = count_q;
        for (int k = 0; k < SLOTS; k++) unit_o[k*UNIT_W +: UNIT_W] = unit_q[k];
    end

    // Marks that at least one clock has passed since reset released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2
    stall_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(stall_i)) |-> (count_q == '0));

    // R2
    oldest_issues_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(valid_i[0] && !stall_i)) |-> (count_q != '0));

    generate
        for (genvar j = 0; j < SLOTS; j++) begin : g_chk_slot
            // R3
            contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (count_q > CNT_W'(j)) == (unit_q[j] != U_NONE));

            if (j >= INT_SLOTS) begin : g_upper
                // R4
                upper_slot_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    !(unit_q[j] inside {U_IEU0, U_IEU1, U_LSU}));
            end

            if (j > 0) begin : g_later
                // R6
                whole_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    unit_q[j] != U_WHOLE);
                // R5
                for (genvar i = 0; i < j; i++) begin : g_older
                    ieu_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                        !((unit_q[i] == U_IEU1) && (unit_q[j] == U_IEU0)));
                end
            end
        end

        for (genvar u = 0; u < 6; u++) begin : g_chk_unit
            logic [SLOTS-1:0] hit;
            always_comb begin
                for (int k = 0; k < SLOTS; k++) hit[k] = (unit_q[k] == UNIT_W'(u));
            end
            // R10
            unit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(hit));
        end
    endgenerate

    // R6
    whole_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_q[0] == U_WHOLE) |-> (count_q == CNT_W'(1)));

endmodule

// File: tb/test_dgf_group_former.sv
module test_dgf_group_former;

    localparam int SLOTS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall_i = 1'b0;
    logic [3:0]  valid_i = '0;
    logic [15:0] class_i = '0;
    logic [3:0]  dbl_i = '0;
    logic [2:0]  count_o;
    logic [11:0] unit_o;

    int checks = 0;
    int fails  = 0;

    logic [2:0]  prev_cnt;
    logic [11:0] prev_unit;

    dgf_group_former i_dgf_group_former (
        .clk     (clk),
        .rst_n   (rst_n),
        .stall_i (stall_i),
        .valid_i (valid_i),
        .class_i (class_i),
        .dbl_i   (dbl_i),
        .count_o (count_o),
        .unit_o  (unit_o)
    );

    always #2.5 clk = ~clk;

    // Reference model written from the requirements.
    function automatic void model(input logic st, input logic [3:0] v,
                                  input logic [15:0] c, input logic [3:0] d,
                                  output logic [2:0] cnt, output logic [11:0] un);
        bit i0 = 0, i1 = 0, ls = 0, ct = 0, fa = 0, fm = 0, fs = 0, fd = 0;
        bit go = !st;
        cnt = 0;
        un  = 12'hFFF;
        for (int k = 0; k < 4; k++) begin
            logic [3:0] cl = c[k*4 +: 4];
            bit ok = 0, stop = 0, fp = 0;
            logic [2:0] u = 3'd7;
            if (!go || !v[k]) break;
            case (cl)
                4'd0: begin ok = (k < 3) && !i1; u = i0 ? 3'd1 : 3'd0; end
                4'd1: begin ok = (k < 3) && !i0 && !i1; u = 3'd0; end
                4'd2: begin ok = (k < 3) && !i1; u = 3'd1; end
                4'd3, 4'd4: begin ok = (k < 3) && !ls; u = 3'd2; end
                4'd5: begin ok = !ct; u = 3'd3; end
                4'd6: begin ok = (k == 0); u = 3'd3; end
                4'd8: begin ok = !fa; u = 3'd4; fp = 1; end
                4'd9: begin ok = !fm; u = 3'd5; fp = 1; end
                4'd10: begin ok = (k == 0); u = 3'd5; fp = 1; end
                default: begin ok = (k == 0); u = 3'd6; stop = 1; end
            endcase
            if (fp && fs && (fd != d[k])) ok = 0;
            if (!ok) break;
            un[k*3 +: 3] = u;
            cnt++;
            case (u)
                3'd0: i0 = 1;
                3'd1: i1 = 1;
                3'd2: ls = 1;
                3'd3: begin ct = 1; if (cl == 4'd6) i1 = 1; end
                3'd4: fa = 1;
                3'd5: fm = 1;
                default: ;
            endcase
            if (fp) begin fs = 1; fd = d[k]; end
            if (stop) go = 0;
        end
    endfunction

    task automatic check(input string req, input logic [2:0] ec, input logic [11:0] eu);
        checks++;
        if (count_o !== ec || unit_o !== eu) begin
            fails++;
            $display("FAIL %s: count=%0d units=%h expected count=%0d units=%h",
                     req, count_o, unit_o, ec, eu);
        end
    endtask

    // Drive a window at a falling edge, check hold before the edge and result after it.
    task automatic apply(input string req, input logic st, input logic [3:0] v,
                         input logic [15:0] c, input logic [3:0] d);
        logic [2:0]  ec;
        logic [11:0] eu;
        @(negedge clk);
        prev_cnt  = count_o;
        prev_unit = unit_o;
        stall_i = st; valid_i = v; class_i = c; dbl_i = d;
        #1;
        check("R12 hold", prev_cnt, prev_unit);
        model(st, v, c, d, ec, eu);
        @(posedge clk);
        @(negedge clk);
        check(req, ec, eu);
    endtask

    function automatic logic [15:0] cls4(input int a, input int b, input int c, input int e);
        return {4'(e), 4'(c), 4'(b), 4'(a)};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 reset", 3'd0, 12'hFFF);
        rst_n = 1'b1;

        // R2 stall and invalid oldest
        apply("R2 stall", 1'b1, 4'hF, cls4(0, 2, 3, 5), 4'h0);
        apply("R2 invalid oldest", 1'b0, 4'hE, cls4(0, 2, 3, 5), 4'h0);
        // R3 hole in window
        apply("R3 hole", 1'b0, 4'b0101, cls4(0, 0, 3, 5), 4'h0);
        // R5 pairing orders
        apply("R5 alu then cmp", 1'b0, 4'b0011, cls4(0, 2, 0, 0), 4'h0);
        apply("R5 cmp then alu", 1'b0, 4'b0011, cls4(2, 0, 0, 0), 4'h0);
        apply("R5 alu then shift", 1'b0, 4'b0011, cls4(0, 1, 0, 0), 4'h0);
        apply("R5 shift alu load branch", 1'b0, 4'hF, cls4(1, 0, 3, 5), 4'h0);
        // R4 slot limits
        apply("R4 alu in slot3", 1'b0, 4'hF, cls4(0, 3, 5, 0), 4'h0);
        apply("R4 fp in slot3", 1'b0, 4'hF, cls4(0, 3, 8, 9), 4'h0);
        // R6 issue-alone classes
        apply("R6 solo first", 1'b0, 4'hF, cls4(7, 0, 3, 5), 4'h0);
        apply("R6 solo second", 1'b0, 4'hF, cls4(0, 7, 3, 5), 4'h0);
        apply("R6 reserved code", 1'b0, 4'hF, cls4(12, 8, 3, 5), 4'h0);
        // R7 call/jump
        apply("R7 call then load", 1'b0, 4'h3, cls4(6, 3, 0, 0), 4'h0);
        apply("R7 call then alu", 1'b0, 4'h3, cls4(6, 0, 0, 0), 4'h0);
        apply("R7 alu then call", 1'b0, 4'h3, cls4(0, 6, 0, 0), 4'h0);
        // R8 FP divide
        apply("R8 fdiv then fadd", 1'b0, 4'h3, cls4(10, 8, 0, 0), 4'h3);
        apply("R8 load then fdiv", 1'b0, 4'h3, cls4(3, 10, 0, 0), 4'h0);
        // R9 precision mixing
        apply("R9 mixed precision", 1'b0, 4'h3, cls4(8, 9, 0, 0), 4'b0010);
        apply("R9 same double", 1'b0, 4'h3, cls4(8, 9, 0, 0), 4'b0011);
        // R10 one per unit
        apply("R10 two memory", 1'b0, 4'h3, cls4(3, 4, 0, 0), 4'h0);
        apply("R10 two fadd", 1'b0, 4'h3, cls4(8, 8, 0, 0), 4'h0);
        apply("R10 two branch", 1'b0, 4'h3, cls4(5, 5, 0, 0), 4'h0);
        // R11 compare with its branch
        apply("R11 cmp branch", 1'b0, 4'h3, cls4(2, 5, 0, 0), 4'h0);

        // Random windows across all rules
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] c;
            for (int k = 0; k < 4; k++) begin
                int r = $urandom_range(0, 19);
                c[k*4 +: 4] = (r < 16) ? 4'(r) : 4'(r - 16);
            end
            apply("R3 R4 R5 R9 R10 random", ($urandom_range(0, 15) == 0),
                  ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'hF,
                  c, 4'($urandom));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule